// File: doc/BRIEF.md
# Bit-Reversed Duty-Cycle Modulator

This block turns an N-bit code into a one-bit stream whose average high fraction is code/2^N, intended to drive a resistor-capacitor low-pass filter acting as a simple DAC. A plain pulse-width modulator puts all high cycles of a period into one pulse. This block spreads them across the period instead. The ripple energy therefore sits at the highest frequency the code allows, where a first-order filter removes it most cheaply.

A free-running counter advances on every enabled clock. In each enabled cycle at most one counter bit goes from 0 to 1. That rising event is gated with the data bit of mirrored weight, so that the lowest counter bit, which rises every other cycle, carries the data MSB. The gated events are ORed and registered to form the output. A new code is staged on a load strobe and is applied only at the counter wrap, so every period uses exactly one code.

Top module: `bitrev_dcm`

## Requirements
- R1: While rst_ni is low, pwm_o is 0, the counter and its previous-value copy are 0, and both the staged and the active code are 0.
- R2: The counter advances by one on every cycle with en_i high and wraps from all ones to zero, so the output pattern repeats every 2^N enabled cycles.
- R3: In an enabled cycle, the registered output becomes 1 when some counter bit i goes from 0 to 1 in that cycle while active code bit N-1-i is 1. The code MSB gates counter bit 0 and the code LSB gates counter bit N-1.
- R4: Over any full counter period, the number of high output cycles equals the active code value. Code 0 gives a constant low.
- R5: The enabled cycle in which the counter goes from all ones to zero always gives a low output. The largest duty is therefore (2^N-1)/2^N (code all ones).
- R6: Code 2^(N-1) gives an output that is high exactly for odd counter values, which is a square wave at half the enabled clock rate.
- R7: Code 2^(N-1)+1 gives the R6 pattern plus one extra high cycle, at counter value 2^(N-1).
- R8: load_i captures data_i into a staging register in any cycle, whatever the state of en_i. The staged code moves to the active code only on the enabled edge where the counter wraps. A load on that same edge goes directly into the active code.
- R9: While en_i is low, the counter, the previous-value register and pwm_o all hold their values.
- R10: pwm_o is registered. After the enabled edge at which the counter held value k, pwm_o shows the result for k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable for counter and output |
| load_i | input | 1 | Strobe that stages data_i |
| data_i | input | WIDTH | Code to stage |
| pwm_o | output | 1 | Registered modulated output |

## Verification
The bench sweeps every code and counts the high cycles in one period. A wrong bit mapping, for example non-reversed gating, leaves that count wrong for every asymmetric code. It compares the exact cycle pattern of the mid-scale code, the mid-scale-plus-one code and several single-bit codes, so an off-by-one output latency or a wrap cycle that goes high shows up as a shifted or extra pulse. It loads a code in the middle of a period and checks that the running period keeps the old count. It also loads on the wrapping edge itself and checks the bypass path. It stops the enable while the output is high and then verifies that no counter step was lost or repeated.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int unsigned DCM_MIN_WIDTH = 2;
  localparam int unsigned DCM_MAX_WIDTH = 16;

  function automatic bit dcm_width_ok(input int unsigned w);
    return (w >= DCM_MIN_WIDTH) && (w <= DCM_MAX_WIDTH);
  endfunction
endpackage

// File: rtl/dcm_counter.sv
module dcm_counter #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (en_i) begin
      prev_q <= cnt_q;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign prev_o = prev_q;
  assign wrap_o = en_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/dcm_word_hold.sv
module dcm_word_hold #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             wrap_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] staged_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
    end else if (load_i) begin
      staged_q <= data_i;
    end
  end

  // a load on the wrap edge goes straight into the active code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
    end else if (wrap_i) begin
      active_q <= load_i ? data_i : staged_q;
    end
  end

  assign word_o = active_q;
endmodule

// File: rtl/dcm_rise_gate.sv
module dcm_rise_gate #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] rise_o,
  output logic             pwm_o
);
  logic [WIDTH-1:0] gated;
  logic             pwm_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rise_o[i] = cnt_i[i] & ~prev_i[i];
    assign gated[i]  = rise_o[i] & word_i[WIDTH-1-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else if (en_i) begin
      pwm_q <= |gated;
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/bitrev_dcm.sv
module bitrev_dcm #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             pwm_o
);
  import dcm_pkg::*;

  logic [WIDTH-1:0] cnt_q, prev_q, word_q, rise_w;
  logic             wrap_w;

  initial begin
    if (!dcm_width_ok(WIDTH)) $display("bitrev_dcm: WIDTH %0d out of range", WIDTH);
  end

  dcm_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cnt_o  (cnt_q),
    .prev_o (prev_q),
    .wrap_o (wrap_w)
  );

  dcm_word_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (data_i),
    .wrap_i (wrap_w),
    .word_o (word_q)
  );

  dcm_rise_gate #(.WIDTH(WIDTH)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cnt_i  (cnt_q),
    .prev_i (prev_q),
    .word_i (word_q),
    .rise_o (rise_w),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/bitrev_dcm_chk.sv
module bitrev_dcm_chk #(
  parameter int unsigned WIDTH = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [WIDTH-1:0] cnt_q,
  input logic [WIDTH-1:0] prev_q,
  input logic [WIDTH-1:0] word_q,
  input logic [WIDTH-1:0] rise_w,
  input logic             pwm_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (!pwm_o && cnt_q == '0 && word_q == '0)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_SINGLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(rise_w)); // R3
  AST_LSB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cnt_q[0] |=> pwm_o == $past(word_q[WIDTH-1])); // R3
  AST_WRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cnt_q == '0 |=> !pwm_o); // R5
  AST_WORD_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && cnt_q == CNT_MAX) |=> $stable(word_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pwm_o) && $stable(cnt_q) && $stable(prev_q))); // R9
endmodule

bind bitrev_dcm bitrev_dcm_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .cnt_q  (cnt_q),
  .prev_q (prev_q),
  .word_q (word_q),
  .rise_w (rise_w),
  .pwm_o  (pwm_o)
);

// File: tb/bitrev_dcm_tb.sv
module bitrev_dcm_tb;
  localparam int W = 6;
  localparam int P = 1 << W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         pwm_o;

  int n_run = 0;
  int n_fail = 0;

  // {code, high pattern for counter values 0..15}; expected count = code
  localparam logic [21:0] VEC [0:9] = '{
    {6'd32, 16'hAAAA}, {6'd16, 16'h4444}, {6'd8, 16'h1010}, {6'd4, 16'h0100},
    {6'd2, 16'h0000},  {6'd48, 16'hEEEE}, {6'd63, 16'hFFFE}, {6'd0, 16'h0000},
    {6'd33, 16'hAAAA}, {6'd5, 16'h0100}
  };

  always #2 clk_i = ~clk_i;

  bitrev_dcm #(.WIDTH(W)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (load_i),
    .data_i (data_i),
    .pwm_o  (pwm_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  // reset, stage code, run the first period (code 0 active); next tick samples counter value 0
  task automatic start(input logic [W-1:0] code);
    int hi;
    rst_ni = 1'b0; en_i = 1'b0; load_i = 1'b0;
    tick; tick;
    rst_ni = 1'b1;
    tick;
    load_i = 1'b1; data_i = code;
    tick;
    load_i = 1'b0; en_i = 1'b1;
    hi = 0;
    for (int k = 0; k < P; k++) begin
      tick;
      hi += int'(pwm_o);
    end
    check(hi == 0, "R8 staged code waits for wrap", hi, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi;
    tick;
    check(pwm_o == 1'b0, "R1 reset output", int'(pwm_o), 0);

    // table walk: R3 R6 R10 pattern, R4 count
    for (int v = 0; v < 10; v++) begin
      logic [5:0]  code;
      logic [15:0] pat;
      code = VEC[v][21:16];
      pat  = VEC[v][15:0];
      start(code);
      hi = 0;
      for (int k = 0; k < P; k++) begin
        tick;
        hi += int'(pwm_o);
        if (k < 16) check(pwm_o == pat[k], "R3 R10 pattern", int'(pwm_o), int'(pat[k]));
      end
      check(hi == int'(code), "R4 high count", hi, int'(code));
    end

    // R4 R5 sweep of every code
    for (int c = 0; c < P; c++) begin
      start(W'(c));
      hi = 0;
      for (int k = 0; k < P; k++) begin
        tick;
        hi += int'(pwm_o);
        if (k == 0) check(pwm_o == 1'b0, "R5 wrap cycle low", int'(pwm_o), 0);
      end
      check(hi == c, "R4 sweep count", hi, c);
    end

    // R6 R7 full-period patterns
    start(6'd32);
    for (int k = 0; k < P; k++) begin
      tick;
      check(pwm_o == k[0], "R6 half-rate square", int'(pwm_o), int'(k[0]));
    end
    start(6'd33);
    for (int k = 0; k < P; k++) begin
      bit e;
      e = k[0] || (k == 32);
      tick;
      check(pwm_o == e, "R7 extra pulse", int'(pwm_o), int'(e));
    end

    // R2 repetition every 2^N cycles with code 1
    start(6'd1);
    for (int k = 0; k < 2 * P; k++) begin
      bit e;
      e = (k % P) == 32;
      tick;
      check(pwm_o == e, "R2 period repeat", int'(pwm_o), int'(e));
    end

    // R9 enable low holds everything
    start(6'd32);
    hi = 0;
    for (int k = 0; k < 6; k++) begin
      tick;
      hi += int'(pwm_o);
    end
    en_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      tick;
      check(pwm_o == 1'b1, "R9 hold while disabled", int'(pwm_o), 1);
    end
    en_i = 1'b1;
    for (int k = 6; k < P; k++) begin
      tick;
      hi += int'(pwm_o);
      if (k == 6) check(pwm_o == 1'b0, "R9 resume value", int'(pwm_o), 0);
    end
    check(hi == 32, "R9 no step lost", hi, 32);

    // R8 mid-period load and load on the wrap edge
    start(6'd32);
    hi = 0;
    for (int k = 0; k < P - 1; k++) begin
      tick;
      hi += int'(pwm_o);
      load_i = (k == 10) || (k == P - 2);
      data_i = (k == P - 2) ? 6'd16 : 6'd0;
    end
    check(hi == 31, "R8 running period unaffected", hi, 31);
    tick;
    load_i = 1'b0;
    check(pwm_o == 1'b1, "R8 last cycle old code", int'(pwm_o), 1);
    hi = 0;
    for (int k = 0; k < P; k++) begin
      tick;
      hi += int'(pwm_o);
    end
    check(hi == 16, "R8 wrap-edge load applied", hi, 16);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule